// File: doc/BRIEF.md
# Differential Phase Detector Back End

This block is the decision stage of a non-coherent binary differential phase receiver. Each accepted complex sample is multiplied against the sample accepted before it, and the real part of that product is formed. This correlation is positive when the phase has not moved and negative when it has flipped. No carrier or phase reference is needed.

A moving sum over the last ten correlations smooths out the noise. The sign of that sum gives a hard bit. Input samples arrive with a strobe that may be low on any cycle. The block only moves forward on strobed samples.

The smoothed metric goes out with the bit, so a later stage can use it as a soft value or a quality figure. Widths and the window length are parameters. The internal sums carry enough guard bits that no legal input can wrap them.

Top module: `dpsk_detect`

## Requirements
- R1: After reset, `det_valid` is 0, `det_metric` is 0 and `det_bit` is 0.
- R2: For an accepted sample n, the correlation is c[n] = I[n]*I[n-1] + Q[n]*Q[n-1], computed on signed two's complement values. The previous I and Q are zero for the first sample after reset.
- R3: `det_metric` equals the exact signed sum of the ten most recent correlations, carried in 29 bits.
- R4: `det_bit` is 1 when the metric is negative and 0 when the metric is zero or positive.
- R5: `det_valid` stays 0 until ten samples have been accepted since reset. From the tenth sample on, it pulses for one cycle for each accepted sample.
- R6: The result for a sample accepted at clock edge t is on the outputs after edge t+2.
- R7: A cycle with `smp_valid` low is ignored. The I and Q values on such a cycle have no effect, the history is unchanged, and the outputs hold their last values with `det_valid` low.
- R8: Full-scale inputs, including -2048 on both rails, produce the exact metric with no wrap. For example, ten products of -2048 by -2048 on both rails give +83886080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_i | input | 12 | In-phase sample, signed |
| smp_q | input | 12 | Quadrature sample, signed |
| det_valid | output | 1 | One-cycle strobe for a new decision |
| det_bit | output | 1 | Hard decision: 1 for a negative metric |
| det_metric | output | 29 | Signed moving sum of ten correlations |

## Verification
The bench drives four kinds of input.
- A constant phase gives a steady run of 0 decisions, and an alternating sign gives a steady run of 1 decisions. Between them, these two show whether the sign of the correlation and the slicer polarity are correct.
- Random samples with random idle gaps separate a design that advances on every clock from one that advances only on strobes. The gaps also put random values on the idle cycles, which must be ignored.
- Full-scale negative values on both rails catch any truncated guard bit or dropped sign extension.
- The first ten samples after reset show whether the warm-up gating and the cleared history are correct.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
   // Number of extra bits needed so that a sum of n terms cannot wrap.
   function automatic int guard_bits(input int n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction
endpackage

// File: rtl/dpsk_correlator.sv
module dpsk_correlator #(
   parameter int SAMPLE_W = 12,
   parameter int CORR_W   = 2*SAMPLE_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_v,
   input  logic signed [SAMPLE_W-1:0] in_i,
   input  logic signed [SAMPLE_W-1:0] in_q,
   output logic                      corr_v,
   output logic signed [CORR_W-1:0]  corr
);
   localparam int PROD_W = 2*SAMPLE_W;

   logic signed [SAMPLE_W-1:0] last_i, last_q;
   logic signed [PROD_W-1:0]   prod_i, prod_q;
   logic signed [CORR_W-1:0]   corr_d;

   always_comb begin
      prod_i = in_i * last_i;
      prod_q = in_q * last_q;
      corr_d = {prod_i[PROD_W-1], prod_i} + {prod_q[PROD_W-1], prod_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_i <= '0;
         last_q <= '0;
         corr   <= '0;
         corr_v <= 1'b0;
      end else begin
         corr_v <= in_v;
         if (in_v) begin
            last_i <= in_i;
            last_q <= in_q;
            corr   <= corr_d;
         end
      end
   end

   AST_IDLE_KEEPS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      !in_v |=> ($stable(last_i) && $stable(last_q) && $stable(corr))) else $error("idle changed history"); // R7
endmodule

// File: rtl/dpsk_smoother.sv
module dpsk_smoother #(
   parameter int CORR_W = 25,
   parameter int LEN    = 10,
   parameter int SUM_W  = CORR_W + dpsk_pkg::guard_bits(LEN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     corr_v,
   input  logic signed [CORR_W-1:0] corr,
   output logic                     sum_v,
   output logic signed [SUM_W-1:0]  sum_q
);
   localparam int    FILL_W    = $clog2(LEN + 1);
   localparam longint SUM_BOUND = longint'(LEN) * (longint'(1) << (CORR_W - 2));

   logic signed [CORR_W-1:0] taps [LEN];
   logic [FILL_W-1:0]        fill;
   logic signed [SUM_W-1:0]  add_term, sub_term;

   assign add_term = {{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr};
   assign sub_term = {{(SUM_W-CORR_W){taps[LEN-1][CORR_W-1]}}, taps[LEN-1]};

   // Delay line: each tap takes its neighbour on every accepted correlation.
   for (genvar k = 0; k < LEN; k++) begin : g_tap
      always_ff @(posedge clk) begin
         if (!rst_n) taps[k] <= '0;
         else if (corr_v) begin
            if (k == 0) taps[k] <= corr;
            else        taps[k] <= taps[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         fill  <= '0;
         sum_v <= 1'b0;
      end else begin
         sum_v <= 1'b0;
         if (corr_v) begin
            sum_q <= sum_q + add_term - sub_term;
            if (fill != FILL_W'(LEN)) fill <= fill + 1'b1;
            sum_v <= (fill >= FILL_W'(LEN - 1));
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(sum_q) <= SUM_BOUND) && (longint'(sum_q) >= -SUM_BOUND)) else $error("sum out of range"); // R8
   AST_WARMUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      sum_v |-> (fill == FILL_W'(LEN))) else $error("early strobe"); // R5
   AST_IDLE_HOLDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_v |=> $stable(sum_q)) else $error("sum moved while idle"); // R7
endmodule

// File: rtl/dpsk_slicer.sv
module dpsk_slicer #(
   parameter int SUM_W = 29
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sum_v,
   input  logic signed [SUM_W-1:0] sum_q,
   output logic                    det_valid,
   output logic                    det_bit,
   output logic signed [SUM_W-1:0] det_metric
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_valid  <= 1'b0;
         det_bit    <= 1'b0;
         det_metric <= '0;
      end else begin
         det_valid <= sum_v;
         if (sum_v) begin
            det_metric <= sum_q;
            det_bit    <= sum_q[SUM_W-1];
         end
      end
   end

   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !sum_v |=> ($stable(det_metric) && $stable(det_bit))) else $error("output moved"); // R7
   AST_STROBE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      det_valid |-> $past(sum_v)) else $error("stray strobe"); // R6
endmodule

// File: rtl/dpsk_detect.sv
module dpsk_detect #(
   parameter int SAMPLE_W = 12,
   parameter int WIN_LEN  = 10,
   parameter int CORR_W   = 2*SAMPLE_W + 1,
   parameter int METRIC_W = CORR_W + dpsk_pkg::guard_bits(WIN_LEN)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_i,
   input  logic signed [SAMPLE_W-1:0] smp_q,
   output logic                       det_valid,
   output logic                       det_bit,
   output logic signed [METRIC_W-1:0] det_metric
);
   if (SAMPLE_W < 2) begin : g_bad_w
      $error("SAMPLE_W must be at least 2");
   end
   if (WIN_LEN < 2) begin : g_bad_len
      $error("WIN_LEN must be at least 2");
   end
   if (CORR_W < 2*SAMPLE_W + 1) begin : g_bad_corr
      $error("CORR_W lacks a guard bit");
   end
   if (METRIC_W < CORR_W + dpsk_pkg::guard_bits(WIN_LEN)) begin : g_bad_metric
      $error("METRIC_W lacks guard bits");
   end

   logic                     corr_v, sum_v;
   logic signed [CORR_W-1:0] corr;
   logic signed [METRIC_W-1:0] sum_q;

   dpsk_correlator #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W)) u_corr (
      .clk(clk), .rst_n(rst_n), .in_v(smp_valid), .in_i(smp_i), .in_q(smp_q),
      .corr_v(corr_v), .corr(corr));

   dpsk_smoother #(.CORR_W(CORR_W), .LEN(WIN_LEN), .SUM_W(METRIC_W)) u_smooth (
      .clk(clk), .rst_n(rst_n), .corr_v(corr_v), .corr(corr),
      .sum_v(sum_v), .sum_q(sum_q));

   dpsk_slicer #(.SUM_W(METRIC_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .sum_v(sum_v), .sum_q(sum_q),
      .det_valid(det_valid), .det_bit(det_bit), .det_metric(det_metric));

   AST_BIT_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      det_valid |-> (det_bit == (det_metric < 0))) else $error("bit not sign"); // R4
endmodule

// File: tb/dpsk_detect_bench.sv
module dpsk_detect_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic signed [11:0] smp_i = '0, smp_q = '0;
   logic det_valid, det_bit;
   logic signed [28:0] det_metric;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // reference state
   longint hist[$];
   longint prev_i = 0, prev_q = 0;
   int     accepted = 0;
   bit     ev[3];
   longint em[3];
   longint held_metric = 0;
   bit     held_bit = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpsk_detect u_dpsk_detect (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
      .det_valid(det_valid), .det_bit(det_bit), .det_metric(det_metric));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge: compare outputs with the model's third stage.
   task automatic compare(input string tag);
      chk(det_valid == ev[2], {"R5/R6 valid ", tag}, det_valid, ev[2]);
      if (ev[2]) begin
         held_metric = em[2];
         held_bit    = (em[2] < 0);
      end
      chk(longint'(det_metric) == held_metric, {"R3/R7 metric ", tag}, det_metric, held_metric);
      chk(det_bit == held_bit, {"R4 bit ", tag}, det_bit, held_bit);
   endtask

   task automatic step(input bit v, input int i, input int q, input string tag);
      bit     nv;
      longint nm;
      compare(tag);
      smp_valid = v;
      smp_i = 12'(i);
      smp_q = 12'(q);
      nv = 1'b0;
      nm = 0;
      if (v) begin
         hist.push_back(longint'(i) * prev_i + longint'(q) * prev_q);   // R2
         if (hist.size() > 10) void'(hist.pop_front());
         prev_i = i;
         prev_q = q;
         accepted++;
         foreach (hist[k]) nm += hist[k];
         nv = (accepted >= 10);
      end
      @(posedge clk);
      ev[2] = ev[1]; em[2] = em[1];
      ev[1] = ev[0]; em[1] = em[0];
      ev[0] = nv;    em[0] = nm;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      for (int k = 0; k < 3; k++) begin ev[k] = 1'b0; em[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(det_valid == 1'b0, "R1 valid", det_valid, 0);
      chk(det_metric == '0, "R1 metric", det_metric, 0);
      chk(det_bit == 1'b0, "R1 bit", det_bit, 0);
      rst_n = 1'b1;

      // Constant phase: decisions 0 once warmed up (R5 warm-up across first 10)
      for (int n = 0; n < 16; n++) step(1'b1, 700, -300, "const");
      // Alternating sign: decisions 1
      for (int n = 0; n < 16; n++) step(1'b1, (n % 2) ? 900 : -900, (n % 2) ? -400 : 400, "alt");
      // Random samples with idle gaps carrying garbage (R7)
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 2) == 0)
            step(1'b0, $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, "idle");
         else
            step(1'b1, $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, "rand");
      end
      // Full-scale negative on both rails (R8)
      for (int n = 0; n < 14; n++) step(1'b1, -2048, -2048, "fullscale");
      for (int n = 0; n < 4; n++) step(1'b0, 0, 0, "flush");
      chk(held_metric == 64'sd83886080, "R8 peak metric", held_metric, 83886080);
      // Full-scale opposite signs alternating: most negative metric
      for (int n = 0; n < 14; n++) step(1'b1, (n % 2) ? 2047 : -2048, (n % 2) ? 2047 : -2048, "fullneg");
      for (int n = 0; n < 5; n++) step(1'b0, 0, 0, "flush");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule